// File: doc/BRIEF.md
# Reconfigurable SIMD Signed Multiplier

This block is the multiply unit of a 32-bit integer core. It keeps one shared pool of small signed multipliers and uses it in three ways. Packed-byte mode gives four independent byte products. Packed-halfword mode gives two independent halfword products. Full mode gives one 32×32 product. The core presents two operand words, a mode code and a one-cycle start strobe. The unit returns a 64-bit result as a low word and a high word, which the core writes back one after the other. A done pulse marks the cycle in which the result is valid.

No dedicated 32×32 array exists. The full product is built from four 16×16 partial products, combined with shifts of 0, 16 and 32 bits in one multi-input adder:

- the four byte multipliers joined into one unsigned 16×16;
- the two halfword multipliers, each run with one operand half unsigned;
- one additional signed 16×16 multiplier.

The partial products are registered, so the full mode takes one cycle more than the packed modes.

Top module: `simd_mul_unit`

## Requirements
- R1: With mode 2'b00, byte k of A (bits [8k+7:8k]) times byte k of B, both signed, gives a 16-bit signed product placed in result bits [16k+15:16k], for k = 0..3.
- R2: With mode 2'b01, halfword h of A times halfword h of B, both signed, gives a 32-bit signed product. The h = 0 product goes to result bits [31:0] and the h = 1 product to bits [63:32].
- R3: With mode 2'b10, the result is the full 64-bit two's-complement product of A and B. res_lo carries bits [31:0] and res_hi carries bits [63:32].
- R4: Mode 2'b11 is reserved. It completes like a packed mode and yields an all-zero result.
- R5: For modes 2'b00, 2'b01 and 2'b11, done is high exactly one cycle after the cycle in which start is sampled. Starts in consecutive cycles give a done pulse in each following cycle.
- R6: For mode 2'b10, done is low one cycle after start and high two cycles after start.
- R7: The result stays unchanged in every cycle in which done is low, and done falls after its pulse when no new start arrives.
- R8: A start sampled while a full-mode product is still in its second stage is ignored. The pending product completes with its own operands, and no extra done pulse follows.
- R9: During reset, done is low and both result words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the current operands and mode |
| mode | input | 2 | 00 packed bytes, 01 packed halfwords, 10 full 32×32, 11 reserved |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| done | output | 1 | Result valid pulse |
| res_lo | output | 32 | Result bits [31:0], first write-back word |
| res_hi | output | 32 | Result bits [63:32], second write-back word |

## Verification
The bench aims at the most negative lane values (−128·−128, −32768·−32768, −2^31·−2^31). A lane sized one bit too narrow, or a missing sign extension, wraps these to negative numbers. It drives full-mode operands whose low halves have the top bit set. A design that treats the low half as signed subtracts 2^32-scaled error terms, and the high word comes out wrong. It also issues a start while a full product is still pending, and back-to-back packed starts. A design that accepts the overlapping start corrupts the pending result or produces a stray done pulse. A design that drops a pipelined start loses one of the two results.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

   typedef enum logic [1:0] {
      MODE_B8  = 2'b00,
      MODE_H16 = 2'b01,
      MODE_W32 = 2'b10,
      MODE_RSV = 2'b11
   } mul_mode_e;

   function automatic int unsigned quad_width(input int unsigned lane_w);
      return 4 * lane_w;
   endfunction

endpackage

// File: rtl/smul_cell.sv
module smul_cell #(
   parameter int unsigned AW = 9,
   parameter int unsigned BW = 9
) (
   input  logic signed [AW-1:0]    a,
   input  logic signed [BW-1:0]    b,
   output logic signed [AW+BW-1:0] p
);
   generate
      if (AW < 2 || BW < 2) begin : g_bad_width
         $error("smul_cell: operand widths must be at least 2");
      end
   endgenerate

   assign p = a * b;
endmodule

// File: rtl/byte_quad_mul.sv
module byte_quad_mul #(
   parameter int unsigned LW = 8
) (
   input  logic            joined,
   input  logic [4*LW-1:0] a,
   input  logic [4*LW-1:0] b,
   output logic [8*LW-1:0] lane_p,
   output logic [4*LW-1:0] joined_p
);
   localparam int unsigned HW = 2 * LW;
   localparam int unsigned QW = 4 * LW;
   localparam int unsigned CW = 2 * LW + 2;

   logic [CW-1:0] cell_p [4];
   logic [QW-1:0] ext_p  [4];

   // Lane mode: cell k multiplies signed byte k of A and B (R1).
   // Joined mode: cells form the unsigned low-half product of A and B,
   // cell k using A byte k/2 and B byte k%2.
   for (genvar k = 0; k < 4; k++) begin : g_cell
      localparam int unsigned AI = k / 2;
      localparam int unsigned BI = k % 2;
      logic [LW:0] ax, bx;

      assign ax = joined ? {1'b0, a[LW*AI +: LW]} : {a[LW*k+LW-1], a[LW*k +: LW]};
      assign bx = joined ? {1'b0, b[LW*BI +: LW]} : {b[LW*k+LW-1], b[LW*k +: LW]};

      smul_cell #(.AW(LW+1), .BW(LW+1)) i_cell (
         .a ($signed(ax)),
         .b ($signed(bx)),
         .p (cell_p[k])
      );

      assign lane_p[HW*k +: HW] = cell_p[k][HW-1:0];
      assign ext_p[k] = {{(QW-CW){cell_p[k][CW-1]}}, cell_p[k]};
   end

   assign joined_p = ext_p[0]
                   + ((ext_p[1] + ext_p[2]) << LW)
                   + (ext_p[3] << HW);
endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit
   import simd_mul_pkg::*;
#(
   parameter int unsigned LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [1:0]              mode,
   input  logic [4*LANE_W-1:0]     op_a,
   input  logic [4*LANE_W-1:0]     op_b,
   output logic                    done,
   output logic [4*LANE_W-1:0]     res_lo,
   output logic [4*LANE_W-1:0]     res_hi
);
   localparam int unsigned HW = 2 * LANE_W;
   localparam int unsigned W  = quad_width(LANE_W);
   localparam int unsigned DW = 2 * W;
   localparam int unsigned MW = 2 * HW + 2;

   generate
      if (LANE_W < 2) begin : g_bad_lane
         $error("simd_mul_unit: LANE_W must be at least 2");
      end
   endgenerate

   mul_mode_e mode_s;
   logic      wide_sel;
   assign mode_s   = mul_mode_e'(mode);
   assign wide_sel = (mode_s == MODE_W32);

   // Byte group: four lanes, or joined unsigned low x low.
   logic [DW-1:0] lane_p;
   logic [W-1:0]  ll_p;

   byte_quad_mul #(.LW(LANE_W)) i_byte_quad (
      .joined   (wide_sel),
      .a        (op_a),
      .b        (op_b),
      .lane_p   (lane_p),
      .joined_p (ll_p)
   );

   // Halfword pair: signed lanes (R2), or the two cross terms of the wide product.
   logic [MW-1:0] half_p [2];

   for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int unsigned BSEL = 1 - h;
      logic [HW-1:0] a_half, b_half;
      logic          a_sgn, b_sgn;
      logic [HW:0]   ax, bx;

      assign a_half = op_a[HW*h +: HW];
      assign b_half = wide_sel ? op_b[HW*BSEL +: HW] : op_b[HW*h +: HW];
      assign a_sgn  = !(wide_sel && h == 0);
      assign b_sgn  = !(wide_sel && h == 1);
      assign ax     = {a_sgn & a_half[HW-1], a_half};
      assign bx     = {b_sgn & b_half[HW-1], b_half};

      smul_cell #(.AW(HW+1), .BW(HW+1)) i_half (
         .a ($signed(ax)),
         .b ($signed(bx)),
         .p (half_p[h])
      );
   end

   // Extra multiplier: signed high x high.
   logic [MW-1:0] hh_p;
   smul_cell #(.AW(HW+1), .BW(HW+1)) i_high (
      .a ($signed({op_a[W-1], op_a[W-1:HW]})),
      .b ($signed({op_b[W-1], op_b[W-1:HW]})),
      .p (hh_p)
   );

   logic [DW-1:0] pack8, pack16;
   assign pack8  = lane_p;
   assign pack16 = {half_p[1][W-1:0], half_p[0][W-1:0]};

   // Stage-one registers for the wide product.
   logic [W-1:0]  ll_q;
   logic [MW-1:0] m0_q, m1_q, hh_q;
   logic          busy;
   logic [DW-1:0] res_q;
   logic          done_q;
   logic [DW-1:0] wide_sum;

   // R3: shifts of 0, HW and W bits feeding one adder.
   assign wide_sum = {{W{1'b0}}, ll_q}
                   + ({{(DW-MW){m0_q[MW-1]}}, m0_q} << HW)
                   + ({{(DW-MW){m1_q[MW-1]}}, m1_q} << HW)
                   + ({{(DW-MW){hh_q[MW-1]}}, hh_q} << W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done_q <= 1'b0;
         res_q  <= '0;
         ll_q   <= '0;
         m0_q   <= '0;
         m1_q   <= '0;
         hh_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (busy) begin
            res_q  <= wide_sum;
            done_q <= 1'b1;
            busy   <= 1'b0;
         end else if (start) begin
            unique case (mode_s)
               MODE_B8: begin
                  res_q  <= pack8;
                  done_q <= 1'b1;
               end
               MODE_H16: begin
                  res_q  <= pack16;
                  done_q <= 1'b1;
               end
               MODE_W32: begin
                  ll_q <= ll_p;
                  m0_q <= half_p[0];
                  m1_q <= half_p[1];
                  hh_q <= hh_p;
                  busy <= 1'b1;
               end
               default: begin
                  res_q  <= '0;
                  done_q <= 1'b1;
               end
            endcase
         end
      end
   end

   assign done   = done_q;
   assign res_lo = res_q[W-1:0];
   assign res_hi = res_q[DW-1:W];

   assert_simd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !wide_sel) |=> (done && !busy));

   assert_wide_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && wide_sel) |=> (busy && !done));

   assert_wide_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (done && !busy));

   assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode_s == MODE_RSV) |=> (res_lo == '0 && res_hi == '0));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({res_hi, res_lo}));

   assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (done && !busy));

endmodule

// File: tb/test_simd_mul_unit.sv
module test_simd_mul_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        done;
   logic [31:0] res_lo, res_hi;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   simd_mul_unit i_simd_mul_unit (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .mode   (mode),
      .op_a   (op_a),
      .op_b   (op_b),
      .done   (done),
      .res_lo (res_lo),
      .res_hi (res_hi)
   );

   // {mode, A, B}
   localparam logic [65:0] VEC [12] = '{
      {2'b00, 32'h807F0102, 32'h80810304},
      {2'b00, 32'hFFFFFFFF, 32'h01020304},
      {2'b00, 32'h7F7F7F7F, 32'h7F7F7F7F},
      {2'b01, 32'h80008000, 32'h80007FFF},
      {2'b01, 32'hFFFF1234, 32'h00025678},
      {2'b10, 32'h80000000, 32'h80000000},
      {2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF},
      {2'b10, 32'h7FFFFFFF, 32'h80000000},
      {2'b10, 32'h12345678, 32'h9ABCDEF0},
      {2'b10, 32'h0000FFFF, 32'h0000FFFF},
      {2'b11, 32'h12345678, 32'h9ABCDEF0},
      {2'b10, 32'hFFFF8000, 32'h00017FFF}
   };

   function automatic logic [63:0] ref_mul(input logic [1:0] m, input logic [31:0] a,
                                           input logic [31:0] b);
      logic [63:0] r;
      r = '0;
      case (m)
         2'b00: for (int k = 0; k < 4; k++) begin
            logic signed [15:0] p;
            p = $signed(a[8*k +: 8]) * $signed(b[8*k +: 8]);
            r[16*k +: 16] = p;
         end
         2'b01: for (int h = 0; h < 2; h++) begin
            logic signed [31:0] p;
            p = $signed(a[16*h +: 16]) * $signed(b[16*h +: 16]);
            r[32*h +: 32] = p;
         end
         2'b10: begin
            logic signed [63:0] sa, sb;
            sa = $signed({{32{a[31]}}, a});
            sb = $signed({{32{b[31]}}, b});
            r  = sa * sb;
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string mode_req(input logic [1:0] m);
      case (m)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic run_op(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b);
      logic [63:0] exp;
      exp = ref_mul(m, a, b);
      @(negedge clk);
      start = 1'b1; mode = m; op_a = a; op_b = b;
      @(negedge clk);
      start = 1'b0;
      if (m == 2'b10) begin
         chk(done == 1'b0, "R6", {63'b0, done}, 64'd0);
         @(negedge clk);
         chk(done == 1'b1, "R6", {63'b0, done}, 64'd1);
      end else begin
         chk(done == 1'b1, "R5", {63'b0, done}, 64'd1);
      end
      chk({res_hi, res_lo} == exp, mode_req(m), {res_hi, res_lo}, exp);
      @(negedge clk);
      chk(done == 1'b0 && {res_hi, res_lo} == exp, "R7", {res_hi, res_lo}, exp);
   endtask

   initial begin
      #(10 * 50000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
   end

   initial begin
      logic [63:0] e1, e2;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(done == 1'b0 && {res_hi, res_lo} == 64'd0, "R9", {res_hi, res_lo}, 64'd0);
      rst_n = 1'b1;

      for (int i = 0; i < 12; i++) begin
         run_op(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);
      end

      // R5: back-to-back packed starts
      e1 = ref_mul(2'b00, 32'h80FF0280, 32'h80FF0381);
      e2 = ref_mul(2'b01, 32'h8001FFFF, 32'h7FFF8000);
      @(negedge clk);
      start = 1'b1; mode = 2'b00; op_a = 32'h80FF0280; op_b = 32'h80FF0381;
      @(negedge clk);
      chk(done == 1'b1 && {res_hi, res_lo} == e1, "R5", {res_hi, res_lo}, e1);
      mode = 2'b01; op_a = 32'h8001FFFF; op_b = 32'h7FFF8000;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1 && {res_hi, res_lo} == e2, "R5", {res_hi, res_lo}, e2);

      // R8: start during the wide second stage is ignored
      e1 = ref_mul(2'b10, 32'h8000FFFF, 32'hFFFF8001);
      @(negedge clk);
      start = 1'b1; mode = 2'b10; op_a = 32'h8000FFFF; op_b = 32'hFFFF8001;
      @(negedge clk);
      mode = 2'b00; op_a = 32'h01010101; op_b = 32'h02020202;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1 && {res_hi, res_lo} == e1, "R8", {res_hi, res_lo}, e1);
      @(negedge clk);
      chk(done == 1'b0 && {res_hi, res_lo} == e1, "R8", {res_hi, res_lo}, e1);

      // R9: reset in the middle of a wide operation
      @(negedge clk);
      start = 1'b1; mode = 2'b10; op_a = 32'h7FFFFFFF; op_b = 32'h7FFFFFFF;
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk(done == 1'b0 && {res_hi, res_lo} == 64'd0, "R9", {res_hi, res_lo}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && {res_hi, res_lo} == 64'd0, "R9", {res_hi, res_lo}, 64'd0);

      report();
   end
endmodule